// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every data beat of one memory burst. A one-cycle start strobe captures a starting column, a burst length of four or eight beats and an ordering style. From the next cycle the block drives one column per clock with a valid flag. A separate flag marks the final beat.

Every address of a burst stays inside the aligned group of four or eight columns that the starting column falls in. The low two bits (length four) or low three bits (length eight) give the position where the burst begins. The bits above them never change during the burst. Two orderings are supported. Sequential ordering counts upward from the start position and wraps around inside the group. Interleaved ordering visits the start position XOR the beat number.

A new start may arrive on any cycle, including the final beat. On the final beat, the next burst then follows with no idle cycle in between.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is high, and in the cycle after it, `valid_o` and `last_o` are low.
- R2: A cycle with `start_i` high makes `valid_o` high from the next cycle. `col_o` equals the sampled `col_i` on that first beat. `valid_o` then stays high for 4 beats when `bl8_i` was 0, or 8 beats when `bl8_i` was 1.
- R3: With `ilv_i` = 0 and `bl8_i` = 0, beat i carries low bits ((s + i) mod 4), where s = `col_i[1:0]`.
- R4: With `ilv_i` = 0 and `bl8_i` = 1, beat i carries low bits ((s + i) mod 8), where s = `col_i[2:0]`.
- R5: With `ilv_i` = 1, beat i carries low bits (s XOR i), where s is the start position for the selected length. Examples: start 1 in length four gives 1-0-3-2, and start 5 in length eight gives 5-4-7-6-1-0-3-2.
- R6: The column bits above the group boundary (bit 2 and up for length four, bit 3 and up for length eight) keep their starting value on every beat. A wrap never carries into them.
- R7: `last_o` is high only on the final beat of a burst. If no start arrives on that beat, `valid_o` is low in the following cycle.
- R8: A start on the final beat begins the new burst in the very next cycle, with no gap.
- R9: `bl8_i`, `ilv_i` and `col_i` are sampled only when `start_i` is high. Changes to them during a burst have no effect on that burst.
- R10: A start during a burst, before its final beat, abandons that burst. The new burst begins with its first beat in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a burst using the inputs sampled this cycle |
| col_i | input | COL_W | Starting column address |
| bl8_i | input | 1 | Burst length: 0 = four beats, 1 = eight beats |
| ilv_i | input | 1 | Ordering: 0 = sequential, 1 = interleaved |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Current beat is the final one of the burst |

## Verification
The final-beat logic and the start capture can act in the same cycle. A new start lands on the beat where `last_o` is high, so the beat counter must wrap and take the new context at once rather than go idle. The bench provokes this by raising `start_i` exactly on the final beat of a four-beat burst. It then checks that the next cycle already shows the first column of the second burst with `valid_o` high, and that the whole second burst runs in order. It also raises a start on a middle beat, where the abandon path competes with the normal increment, and judges the result the same way.

// File: rtl/ddr2_burst_pkg.sv
package ddr2_burst_pkg;

    // Widest burst is eight beats, so three offset bits cover it.
    localparam int OFF_W = 3;

    typedef logic [OFF_W-1:0] off_t;

    typedef enum logic {
        BLEN_FOUR  = 1'b0,
        BLEN_EIGHT = 1'b1
    } blen_e;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } bord_e;

    typedef struct packed {
        off_t  start_off;
        blen_e blen;
        bord_e bord;
    } burst_ctx_t;

    // Bits below the group boundary for a given length.
    function automatic off_t lane_mask(input blen_e b);
        return (b == BLEN_EIGHT) ? off_t'(3'b111) : off_t'(3'b011);
    endfunction

    // Index of the final beat equals the mask value (BL-1).
    function automatic off_t final_index(input blen_e b);
        return lane_mask(b);
    endfunction

    function automatic off_t seq_offset(input off_t s, input off_t i, input blen_e b);
        off_t sum;
        sum = s + i;
        return sum & lane_mask(b);
    endfunction

    function automatic off_t ilv_offset(input off_t s, input off_t i, input blen_e b);
        return (s ^ i) & lane_mask(b);
    endfunction

endpackage

// File: rtl/burst_ctx_reg.sv
module burst_ctx_reg
    import ddr2_burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [COL_W-1:0] col_i,
    input  blen_e            blen_i,
    input  bord_e            bord_i,
    output burst_ctx_t       ctx_o,
    output logic [COL_W-1:0] base_o
);

    logic [COL_W-1:0] low_mask;
    logic [COL_W-1:0] base_d;
    burst_ctx_t       ctx_d;

    always_comb begin
        low_mask        = COL_W'(lane_mask(blen_i));
        base_d          = col_i & ~low_mask;
        ctx_d.start_off = off_t'(col_i[OFF_W-1:0]) & lane_mask(blen_i);
        ctx_d.blen      = blen_i;
        ctx_d.bord      = bord_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_o  <= '{start_off: '0, blen: BLEN_FOUR, bord: ORD_SEQ};
            base_o <= '0;
        end else if (load_i) begin
            ctx_o  <= ctx_d;
            base_o <= base_d;
        end
    end

endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt
    import ddr2_burst_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  blen_e blen_i,
    output off_t  beat_o,
    output logic  active_o,
    output logic  last_o
);

    assign last_o = active_o && (beat_o == final_index(blen_i));

    always_ff @(posedge clk) begin
        if (rst) begin
            active_o <= 1'b0;
            beat_o   <= '0;
        end else if (start_i) begin
            active_o <= 1'b1;
            beat_o   <= '0;
        end else if (active_o) begin
            if (last_o) begin
                active_o <= 1'b0;
                beat_o   <= '0;
            end else begin
                beat_o <= beat_o + off_t'(1);
            end
        end
    end

endmodule

// File: rtl/burst_order_gen.sv
module burst_order_gen
    import ddr2_burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  burst_ctx_t       ctx_i,
    input  logic [COL_W-1:0] base_i,
    input  off_t             beat_i,
    output logic [COL_W-1:0] col_o
);

    off_t off_seq;
    off_t off_ilv;
    off_t off_sel;

    always_comb begin
        off_seq = seq_offset(ctx_i.start_off, beat_i, ctx_i.blen);
        off_ilv = ilv_offset(ctx_i.start_off, beat_i, ctx_i.blen);
        off_sel = (ctx_i.bord == ORD_ILV) ? off_ilv : off_seq;
    end

    // Low bits come from the offset; upper bits pass from the aligned base.
    generate
        if (COL_W > OFF_W) begin : g_wide
            assign col_o = {base_i[COL_W-1:OFF_W], base_i[OFF_W-1:0] | off_sel};
        end else begin : g_narrow
            assign col_o = base_i | off_sel[COL_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import ddr2_burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [COL_W-1:0] col_i,
    input  logic             bl8_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o
);

    burst_ctx_t       ctx_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] col_gen;
    off_t             beat_q;
    logic             active_q;

    burst_ctx_reg #(.COL_W(COL_W)) i_ctx (
        .clk    (clk),
        .rst    (rst),
        .load_i (start_i),
        .col_i  (col_i),
        .blen_i (blen_e'(bl8_i)),
        .bord_i (bord_e'(ilv_i)),
        .ctx_o  (ctx_q),
        .base_o (base_q)
    );

    burst_beat_cnt i_cnt (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .blen_i   (ctx_q.blen),
        .beat_o   (beat_q),
        .active_o (active_q),
        .last_o   (last_o)
    );

    burst_order_gen #(.COL_W(COL_W)) i_ord (
        .ctx_i  (ctx_q),
        .base_i (base_q),
        .beat_i (beat_q),
        .col_o  (col_gen)
    );

    assign valid_o = active_q;
    assign col_o   = active_q ? col_gen : '0;

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [COL_W-1:0] col_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!valid_o && !last_o));

    assert_first_beat_R2: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (valid_o && col_o == $past(col_i)));

    assert_last_in_burst_R7: assert property (@(posedge clk) disable iff (rst)
        last_o |-> valid_o);

    assert_idle_after_last_R7: assert property (@(posedge clk) disable iff (rst)
        (last_o && !start_i) |=> !valid_o);

    assert_no_gap_R8: assert property (@(posedge clk) disable iff (rst)
        (last_o && start_i) |=> valid_o);

    generate
        if (COL_W > 3) begin : g_upper
            assert_group_held_R6: assert property (@(posedge clk) disable iff (rst)
                (valid_o && !last_o && !start_i) |=>
                    (valid_o && col_o[COL_W-1:3] == $past(col_o[COL_W-1:3])));
        end
    endgenerate

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .col_i   (col_i),
    .col_o   (col_o),
    .valid_o (valid_o),
    .last_o  (last_o)
);

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;

    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] col_i = '0;
    logic             bl8_i = 1'b0;
    logic             ilv_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o;
    logic             last_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) i_burst_col_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .col_i   (col_i),
        .bl8_i   (bl8_i),
        .ilv_i   (ilv_i),
        .col_o   (col_o),
        .valid_o (valid_o),
        .last_o  (last_o)
    );

    function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] c,
                                                 input bit b8, input bit il, input int i);
        int m, s, off;
        m   = b8 ? 8 : 4;
        s   = int'(c) % m;
        off = il ? (s ^ i) : ((s + i) % m);
        return COL_W'(int'(c) - s + off);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Called at the negedge where beat 0 is visible; returns at the negedge of the final beat.
    task automatic check_beats(input logic [COL_W-1:0] c, input bit b8, input bit il,
                               input int upto, input string req);
        int n;
        n = b8 ? 8 : 4;
        for (int i = 0; i < n && i <= upto; i++) begin
            chk({req, " valid"}, int'(valid_o), 1);
            chk({req, " col"}, int'(col_o), int'(exp_col(c, b8, il, i)));
            chk({req, " R7 last"}, int'(last_o), int'(i == n - 1));
            if (i < n - 1 && i < upto) @(negedge clk);
        end
    endtask

    // Raise start for one cycle, then scramble inputs (R9); returns at beat-0 negedge.
    task automatic pulse_start(input logic [COL_W-1:0] c, input bit b8, input bit il);
        start_i = 1'b1; col_i = c; bl8_i = b8; ilv_i = il;
        @(negedge clk);
        start_i = 1'b0; col_i = ~c; bl8_i = ~b8; ilv_i = ~il;
    endtask

    task automatic run_burst(input logic [COL_W-1:0] c, input bit b8, input bit il,
                             input string req);
        @(negedge clk);
        pulse_start(c, b8, il);
        check_beats(c, b8, il, 99, req);
        @(negedge clk);
        chk({req, " R7 idle after last"}, int'(valid_o), 0);
        chk({req, " R7 last low"}, int'(last_o), 0);
    endtask

    task automatic test_reset;
        chk("R1 valid in reset", int'(valid_o), 0);
        chk("R1 last in reset", int'(last_o), 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", int'(valid_o), 0);
    endtask

    task automatic test_back_to_back;
        @(negedge clk);
        pulse_start(10'h0D6, 1'b0, 1'b0);
        check_beats(10'h0D6, 1'b0, 1'b0, 99, "R8 first");
        pulse_start(10'h1F5, 1'b1, 1'b1);
        check_beats(10'h1F5, 1'b1, 1'b1, 99, "R8 second no gap");
        @(negedge clk);
        chk("R8 idle after chain", int'(valid_o), 0);
    endtask

    task automatic test_restart;
        @(negedge clk);
        pulse_start(10'h233, 1'b1, 1'b0);
        check_beats(10'h233, 1'b1, 1'b0, 2, "R10 aborted");
        pulse_start(10'h0AE, 1'b0, 1'b1);
        check_beats(10'h0AE, 1'b0, 1'b1, 99, "R10 restarted");
        @(negedge clk);
        chk("R10 idle", int'(valid_o), 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        test_reset();
        run_burst(10'h01A, 1'b0, 1'b0, "R2 R3 seq4 s2");
        run_burst(10'h007, 1'b0, 1'b0, "R3 R6 seq4 s3 bit2 held");
        run_burst(10'h02D, 1'b1, 1'b0, "R4 R6 seq8 s5");
        run_burst(10'h3F8, 1'b1, 1'b0, "R4 seq8 s0");
        run_burst(10'h041, 1'b0, 1'b1, "R5 ilv4 s1");
        run_burst(10'h0C7, 1'b0, 1'b1, "R5 R6 ilv4 s3");
        run_burst(10'h115, 1'b1, 1'b1, "R5 ilv8 s5");
        run_burst(10'h10E, 1'b1, 1'b1, "R5 R9 ilv8 s6");
        test_back_to_back();
        test_restart();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule